// File: doc/BRIEF.md
# Conversion Start Trigger Unit

This unit decides when an analog conversion sequencer begins a new pass over its active channels. It issues a single-cycle `start_pulse` to the sequencer, and one pulse starts the whole sequence. There are two ways to request a start. The first is a self-clearing software strobe, raised for one cycle when the start bit of the control register is written with 1. The second is a hardware trigger. A select field chooses the hardware source from several timer waveform outputs and one external trigger pin.

Every hardware source is synchronised into the system clock domain through a chain of flip-flops. Edge detection is done separately for each source, and the select field then picks which source's rising edge counts. A hardware start therefore follows the pin's rising edge by a few clock periods. The sequencer reports `seq_busy` back to the unit. A small state machine uses it to drop any request that arrives from the start pulse until the sequencer has finished. Dropped requests are not remembered.

The state machine has four states:
- `ST_IDLE` waits for a request.
- `ST_LAUNCH` drives the start pulse.
- `ST_ACK` gives the sequencer one cycle to raise busy.
- `ST_RUN` follows busy until it falls.

Its transitions are:
- IDLE→LAUNCH on a request with busy low.
- IDLE→RUN when busy is high.
- LAUNCH→ACK always.
- ACK→RUN when busy is high.
- ACK→IDLE when busy is low.
- RUN→IDLE when busy falls.

Top module: `trig_unit`

## Requirements
- R1: When `sw_start` is high in a cycle where the unit is idle and `seq_busy` is low, `start_pulse` is high in the next cycle only.
- R2: `trig_sel` values 0 to NUM_TIMERS-1 select `timer_out[trig_sel]`, and the value NUM_TIMERS selects `ext_trig`. Sources that are not selected never cause a start.
- R3: A low-to-high change on the selected source produces exactly one start. The pulse appears SYNC_STAGES+1 clock edges after the first edge that samples the source high, which is 3 edges with the default settings. Holding the source high produces no further start.
- R4: `trig_sel` values above NUM_TIMERS disable hardware triggering. The software strobe still works under these values.
- R5: A request made while `seq_busy` is high, or while the unit is in LAUNCH, ACK or RUN, is dropped. It does not produce a start later.
- R6: A software strobe and a hardware edge in the same cycle give a single start. `start_pulse` is never high for two consecutive cycles, even if `sw_start` is held.
- R7: Changing `trig_sel` to a source that is already high does not produce a start.
- R8: During and after reset `start_pulse` is low. The synchroniser and edge registers are cleared, so no start occurs while all sources stay low.
- R9: If `seq_busy` is low in the cycle after the pulse, the unit is idle again one cycle later. If `seq_busy` is high then, the unit accepts a request starting from the cycle after the one in which `seq_busy` is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | One-cycle software start strobe from the control register write |
| trig_sel | input | SEL_W | Hardware trigger source select |
| timer_out | input | NUM_TIMERS | Timer waveform outputs, asynchronous |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| seq_busy | input | 1 | High while the conversion sequencer runs |
| start_pulse | output | 1 | One-cycle start command to the sequencer |

## Verification
The unit is exercised with the following patterns:
- **Single strobes and single edges** on each selectable source. These separate correct source decoding from cross-talk between sources.
- **A source held high, and a select switched onto a high source.** These tell edge detection apart from level sensing.
- **A strobe coinciding with an edge, and a strobe held for two cycles.** These show whether requests merge into one start.
- **Requests placed during busy, during an externally raised busy, and exactly one cycle before and at the first cycle the unit accepts again.** These are run with a sequencer that goes busy for several cycles and with one that never goes busy. They pin down the blocking window on both sides.

// File: rtl/trig_unit_pkg.sv
package trig_unit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_ACK    = 2'd2,
        ST_RUN    = 2'd3
    } trig_state_e;

endpackage

// File: rtl/trig_sync.sv
// Multi-stage synchroniser for a vector of independent asynchronous bits.
module trig_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/trig_edge_sel.sv
// Rising-edge detection per source, then selection of one edge by code.
module trig_edge_sel #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  lvl,
    input  logic [SEL_W-1:0] sel,
    output logic             hw_req
);

    logic [NSRC-1:0] lvl_prev;
    logic [NSRC-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~lvl_prev[i];
    end

    // Codes at or above NSRC match no source and leave hw_req low.
    always_comb begin
        hw_req = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) hw_req = rise[i];
        end
    end

endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import trig_unit_pkg::*;
#(
    parameter int NUM_TIMERS  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = $clog2(NUM_TIMERS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_start,
    input  logic [SEL_W-1:0]      trig_sel,
    input  logic [NUM_TIMERS-1:0] timer_out,
    input  logic                  ext_trig,
    input  logic                  seq_busy,
    output logic                  start_pulse
);

    localparam int NSRC = NUM_TIMERS + 1;

    logic [NSRC-1:0] src_sync;
    logic            hw_req;
    logic            req_any;
    trig_state_e     state_q;
    trig_state_e     state_d;

    trig_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_trig, timer_out}),
        .sync_out (src_sync)
    );

    trig_edge_sel #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (src_sync),
        .sel    (trig_sel),
        .hw_req (hw_req)
    );

    assign req_any = sw_start | hw_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (seq_busy)     state_d = ST_RUN;
                else if (req_any) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: state_d = ST_ACK;
            ST_ACK: begin
                if (seq_busy) state_d = ST_RUN;
                else          state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (!seq_busy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start_pulse = 1'b0;
        unique case (state_q)
            ST_LAUNCH: start_pulse = 1'b1;
            ST_IDLE, ST_ACK, ST_RUN: start_pulse = 1'b0;
            default: start_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk
    import trig_unit_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int SEL_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_start,
    input logic [SEL_W-1:0] trig_sel,
    input logic             seq_busy,
    input logic             start_pulse,
    input logic             hw_req,
    input trig_state_e      state_q
);

    // R1: an accepted software strobe launches in the next cycle
    p_sw_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sw_start && !seq_busy) |=> start_pulse);

    // R3: an accepted hardware edge launches in the next cycle
    p_hw_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hw_req && !seq_busy) |=> start_pulse);

    // R3: an edge request lasts one cycle for an unchanged select
    p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |=> (!hw_req || trig_sel != $past(trig_sel)));

    // R4: off codes never raise a hardware request
    p_off_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel > SEL_W'(NUM_TIMERS)) |-> !hw_req);

    // R5: no launch while the sequencer is still running
    p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && seq_busy) |=> !start_pulse);

    // R5: a start is only issued from a cycle where busy was low
    p_launch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !$past(seq_busy));

    // R6: the start pulse is never two cycles long
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R9: after the acknowledge cycle the unit is idle or following busy
    p_ack_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |=> (state_q == ST_IDLE || state_q == ST_RUN));

endmodule

bind trig_unit trig_unit_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .SEL_W      (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_start    (sw_start),
    .trig_sel    (trig_sel),
    .seq_busy    (seq_busy),
    .start_pulse (start_pulse),
    .hw_req      (hw_req),
    .state_q     (state_q)
);

// File: tb/test_trig_unit.sv
module test_trig_unit;

    localparam int NT    = 3;
    localparam int SEL_W = $clog2(NT + 2);
    localparam int HW_LAT = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_start = 1'b0;
    logic [SEL_W-1:0] trig_sel = '0;
    logic [NT-1:0]    timer_out = '0;
    logic             ext_trig = 1'b0;
    logic             seq_busy;
    logic             start_pulse;

    int  cyc = 0;
    int  busy_len = 6;
    int  busy_cnt = 0;
    logic ext_busy = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    int    seen = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    trig_unit #(.NUM_TIMERS(NT)) i_trig_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_start    (sw_start),
        .trig_sel    (trig_sel),
        .timer_out   (timer_out),
        .ext_trig    (ext_trig),
        .seq_busy    (seq_busy),
        .start_pulse (start_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Sequencer model: busy from the cycle after a start for busy_len cycles
    always @(posedge clk) begin
        if (start_pulse)       busy_cnt <= busy_len;
        else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
    assign seq_busy = (busy_cnt != 0) | ext_busy;

    // Monitor: pop expected start cycles and compare
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (start_pulse) begin
                seen++;
                checks++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else begin
                    fails++;
                    $display("FAIL %s: start at cycle %0d, expected %0d",
                             (tag_q.size() > 0) ? tag_q[0] : "R5",
                             cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: no start seen, actual none, expected cycle %0d",
                         tag_q[0], exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic expect_at(int c, string tag);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cyc(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic set_src(int idx, logic v);
        if (idx < NT) timer_out[idx] = v;
        else          ext_trig = v;
    endtask

    task automatic sw_go(bit accept, string tag);
        sw_start = 1'b1;
        if (accept) expect_at(cyc + 1, tag);
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic hw_rise(int idx, bit accept, string tag);
        set_src(idx, 1'b1);
        if (accept) expect_at(cyc + HW_LAT, tag);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int base;
        int p;
        // R8: reset state
        idle(4);
        check_eq("R8 pulse in reset", int'(start_pulse), 0);
        rst_n = 1'b1;
        idle(10);
        check_eq("R8 no start after reset", seen, 0);

        // R1: software strobe
        sw_go(1'b1, "R1");
        idle(15);

        // R2, R3: timer 0 edge, then held high
        trig_sel = 0;
        hw_rise(0, 1'b1, "R3 timer0 edge");
        idle(15);
        base = seen;
        idle(15);
        check_eq("R3 held level no restart", seen, base);
        set_src(0, 1'b0);
        idle(5);

        // R2: unselected timer ignored, selected timer fires
        trig_sel = 2;
        base = seen;
        hw_rise(1, 1'b0, "R2");
        idle(15);
        check_eq("R2 unselected source", seen, base);
        hw_rise(2, 1'b1, "R2 timer2 edge");
        idle(15);
        set_src(1, 1'b0);
        set_src(2, 1'b0);
        idle(5);

        // R2: external pin at code NUM_TIMERS
        trig_sel = SEL_W'(NT);
        hw_rise(NT, 1'b1, "R2 external edge");
        idle(15);
        set_src(NT, 1'b0);
        idle(5);

        // R4: off code
        trig_sel = SEL_W'(NT + 2);
        base = seen;
        hw_rise(NT, 1'b0, "R4");
        hw_rise(0, 1'b0, "R4");
        idle(15);
        check_eq("R4 off code no hw start", seen, base);
        sw_go(1'b1, "R4 sw under off code");
        idle(15);
        set_src(NT, 1'b0);
        set_src(0, 1'b0);
        idle(5);

        // R7: select moved onto a source already high
        trig_sel = 0;
        set_src(1, 1'b1);
        idle(6);
        base = seen;
        trig_sel = 1;
        idle(15);
        check_eq("R7 select change no start", seen, base);
        set_src(1, 1'b0);
        trig_sel = 0;
        idle(6);

        // R6: coincident software and hardware requests
        base = seen;
        set_src(0, 1'b1);
        expect_at(cyc + HW_LAT, "R6 merged start");
        idle(2);
        sw_start = 1'b1;
        idle(1);
        sw_start = 1'b0;
        idle(15);
        check_eq("R6 one start for two requests", seen, base + 1);
        set_src(0, 1'b0);
        idle(5);

        // R6: strobe held two cycles
        base = seen;
        sw_start = 1'b1;
        expect_at(cyc + 1, "R6 held strobe");
        idle(2);
        sw_start = 1'b0;
        idle(15);
        check_eq("R6 held strobe single start", seen, base + 1);

        // R5: requests during a running sequence are dropped
        base = seen;
        p = cyc + 1;
        sw_go(1'b1, "R5 first start");
        wait_cyc(p + 3);
        sw_go(1'b0, "R5");
        hw_rise(0, 1'b0, "R5");
        idle(20);
        check_eq("R5 busy drops requests", seen, base + 1);
        set_src(0, 1'b0);
        idle(5);

        // R5: busy raised by the sequencer on its own
        base = seen;
        ext_busy = 1'b1;
        idle(3);
        sw_go(1'b0, "R5");
        hw_rise(0, 1'b0, "R5");
        idle(5);
        ext_busy = 1'b0;
        idle(15);
        check_eq("R5 external busy drops", seen, base);
        set_src(0, 1'b0);
        idle(5);

        // R9: boundary of the blocking window with a busy sequencer
        base = seen;
        p = cyc + 1;
        sw_go(1'b1, "R9 first");
        wait_cyc(p + 1 + busy_len);
        sw_go(1'b0, "R9");
        sw_go(1'b1, "R9 first accepted cycle");
        idle(15);
        check_eq("R9 busy boundary", seen, base + 2);

        // R9: sequencer that never raises busy
        busy_len = 0;
        base = seen;
        p = cyc + 1;
        sw_go(1'b1, "R9 no-busy first");
        wait_cyc(p + 1);
        sw_go(1'b0, "R9");
        sw_go(1'b1, "R9 no-busy reaccept");
        idle(15);
        check_eq("R9 no-busy boundary", seen, base + 2);

        idle(10);
        check_eq("all expected starts seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule